// File: doc/BRIEF.md
# Expanded Memory Page Mapper

This block translates addresses for an 8-bit expanded-memory card in an XT-class machine. The host sees a 64KB page frame in its memory map. The frame is set on a 64KB boundary and is cut into four 16KB windows. Each window has its own 8-bit page register. The page register picks one of 256 physical 16KB pages in a chip-banked SRAM array of up to eight 512KB devices, 4MB in all. When a host memory cycle falls inside the frame, the block produces a 19-bit SRAM address, one active-low chip select, a write or output enable for the SRAM, and a data-buffer enable toward the host bus.

The host loads the page registers through four consecutive I/O ports from a configurable base, and it can read them back. After reset every register holds 00h and the frame ignores memory cycles. The first register write enables the frame. Software can load the four registers with consecutive pages and then use the frame as one flat 64KB region. A device that is not fitted reads as FFh through the pull-ups on its data lines. Because the mapper still drives that value onto the host bus, software can find the installed size by writing and then reading back the first byte of each 512KB region.

The block runs from a local clock and samples the bus strobes on it, so it keeps to standard 8-bit bus timing and never asks for zero-wait-state cycles. A state machine has the states IDLE, IO_WR, IO_RD, MEM_WR and MEM_RD. It moves from IDLE to one of the other four when a matching strobe is sampled low with an address hit. It stays in that state while the strobe is held low. It returns to IDLE on the first clock at which the strobe is sampled high.

Top module: `emm_mapper`

## Requirements
- R1: After reset all four page registers read 00h. Until the first page-register write, memory cycles inside the frame leave every chip select high and the data-buffer enable low.
- R2: An I/O write to port base + k (k = 0..3; bus address bits 9:2 equal to `port_base`, bits 1:0 equal to k) loads page register k from the data bus. An I/O read of the same port drives that register onto `bus_dout` with `bus_doe` high.
- R3: An I/O cycle whose address bits 9:2 differ from `port_base` changes no page register and leaves `bus_doe` low.
- R4: A memory cycle is inside the frame when address bits 19:16 equal `frame_base`. Address bits 15:14 of that cycle choose the page register that supplies the physical page.
- R5: For an in-frame cycle, bits 7:5 of the chosen page drive the one active-low bit of `sram_cs_n` with that index. `sram_addr` is {page bits 4:0, bus address bits 13:0}.
- R6: An in-frame memory write drives `sram_we_n` low, keeps `sram_oe_n` high and `bus_doe` low, and passes `bus_din` to `sram_wdata`.
- R7: An in-frame memory read drives `sram_oe_n` low, keeps `sram_we_n` high, raises `bus_doe`, and passes `sram_rdata` to `bus_dout`. A chip that is not fitted therefore reads as FFh.
- R8: A memory cycle outside the frame leaves all chip selects, `sram_we_n` and `sram_oe_n` high and `bus_doe` low.
- R9: With consecutive pages P..P+3 in registers 0..3, frame offset F (16 bits) reaches physical byte P×16384 + F, where the physical byte is {chip, sram_addr}.
- R10: The outputs of a cycle appear on the clock after the strobe is first sampled low. They hold while the strobe stays low, and they return to idle on the clock after the strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock used to sample the bus strobes |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 20 | Host address bus |
| bus_din | input | 8 | Host data bus toward the card |
| bus_dout | output | 8 | Data from the card toward the host |
| bus_doe | output | 1 | Enables the host data buffer toward the host |
| iow_n | input | 1 | I/O write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| frame_base | input | 4 | Host address bits 19:16 of the page frame |
| port_base | input | 8 | Host address bits 9:2 of the register ports |
| sram_rdata | input | 8 | Read data from the SRAM array (pull-ups give FFh when no chip answers) |
| sram_wdata | output | 8 | Write data to the SRAM array |
| sram_addr | output | 19 | Address inside one 512KB device |
| sram_cs_n | output | 8 | Active-low chip selects, one for each device |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The assertions assume that at most one of the four strobes is low at any time. They also assume that each strobe stays low for at least one clock, and that address and write data stay stable while a strobe is low. If these hold, a cycle's state can be traced to the strobe that started it. The bench drives every cycle from a single task. That task changes address, data and one strobe together on the falling clock edge, holds them for two clocks, releases the strobe and leaves an idle clock before the next cycle. The stimulus therefore never overlaps strobes or changes the address in the middle of a cycle.

// File: rtl/emm_pkg.sv
package emm_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_IO_WR  = 3'd1,
        S_IO_RD  = 3'd2,
        S_MEM_WR = 3'd3,
        S_MEM_RD = 3'd4
    } cyc_state_t;

endpackage

// File: rtl/emm_decode.sv
module emm_decode #(
    parameter int ADDR_W    = 20,
    parameter int WIN_OFS_W = 14,
    parameter int N_WIN     = 4,
    parameter int IO_DEC_W  = 10,
    localparam int WIN_SEL_W = $clog2(N_WIN),
    localparam int FRAME_W   = WIN_OFS_W + WIN_SEL_W,
    localparam int FB_W      = ADDR_W - FRAME_W,
    localparam int PB_W      = IO_DEC_W - WIN_SEL_W
) (
    input  logic [ADDR_W-1:WIN_OFS_W] mem_addr_hi,
    input  logic [IO_DEC_W-1:0]       io_addr,
    input  logic [FB_W-1:0]           frame_base,
    input  logic [PB_W-1:0]           port_base,
    input  logic                      frame_en,
    output logic                      mem_hit,
    output logic                      io_hit,
    output logic [WIN_SEL_W-1:0]      win_sel,
    output logic [WIN_SEL_W-1:0]      reg_idx
);

    // Frame hit needs the frame to be armed by a first register write.
    always_comb begin
        mem_hit = frame_en && (mem_addr_hi[ADDR_W-1:FRAME_W] == frame_base);
        win_sel = mem_addr_hi[FRAME_W-1:WIN_OFS_W];
        io_hit  = (io_addr[IO_DEC_W-1:WIN_SEL_W] == port_base);
        reg_idx = io_addr[WIN_SEL_W-1:0];
    end

endmodule

// File: rtl/emm_page_regs.sv
module emm_page_regs #(
    parameter int N_WIN  = 4,
    parameter int PAGE_W = 8,
    localparam int IDX_W = $clog2(N_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [PAGE_W-1:0] win_page,
    output logic [PAGE_W-1:0] rb_page,
    output logic              frame_en
);

    logic [PAGE_W-1:0] page_q [N_WIN];

    for (genvar g = 0; g < N_WIN; g++) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                page_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_en <= 1'b0;
        end else if (wr_en) begin
            frame_en <= 1'b1;
        end
    end

    assign win_page = page_q[win_idx];
    assign rb_page  = page_q[rb_idx];

    // R2: a register write is visible on the read-back path next cycle.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rb_idx == wr_idx) && $stable(rb_idx)) |=> (rb_page == $past(wr_data)))
        else $error("write did not land");

    // R1: the frame stays disarmed until a write has happened.
    p_arm_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_en && !wr_en) |=> !frame_en)
        else $error("frame armed without write");

endmodule

// File: rtl/emm_cycle_fsm.sv
module emm_cycle_fsm
    import emm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 8,
    parameter int WIN_OFS_W   = 14,
    parameter int CHIP_ADDR_W = 19,
    localparam int PAGE_LO_W  = CHIP_ADDR_W - WIN_OFS_W,
    localparam int CHIP_SEL_W = PAGE_W - PAGE_LO_W,
    localparam int N_CHIPS    = 1 << CHIP_SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iow_n,
    input  logic                   ior_n,
    input  logic                   memw_n,
    input  logic                   memr_n,
    input  logic                   mem_hit,
    input  logic                   io_hit,
    input  logic [WIN_OFS_W-1:0]   win_ofs,
    input  logic [PAGE_W-1:0]      win_page,
    input  logic [PAGE_W-1:0]      rb_page,
    input  logic [DATA_W-1:0]      bus_din,
    input  logic [DATA_W-1:0]      sram_rdata,
    output logic                   reg_wr_en,
    output logic [DATA_W-1:0]      bus_dout,
    output logic                   bus_doe,
    output logic [DATA_W-1:0]      sram_wdata,
    output logic [CHIP_ADDR_W-1:0] sram_addr,
    output logic [N_CHIPS-1:0]     sram_cs_n,
    output logic                   sram_we_n,
    output logic                   sram_oe_n
);

    cyc_state_t state, state_nx;

    logic [WIN_OFS_W-1:0] ofs_q;
    logic [PAGE_W-1:0]    page_q;
    logic [PAGE_W-1:0]    rb_q;
    logic                 cs_active;
    logic                 start;

    // Next-state decision: strobes are exclusive, checked in priority order.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (!iow_n && io_hit)        state_nx = S_IO_WR;
                else if (!ior_n && io_hit)   state_nx = S_IO_RD;
                else if (!memw_n && mem_hit) state_nx = S_MEM_WR;
                else if (!memr_n && mem_hit) state_nx = S_MEM_RD;
            end
            S_IO_WR:  if (iow_n)  state_nx = S_IDLE;
            S_IO_RD:  if (ior_n)  state_nx = S_IDLE;
            S_MEM_WR: if (memw_n) state_nx = S_IDLE;
            S_MEM_RD: if (memr_n) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    assign start     = (state == S_IDLE) && (state_nx != S_IDLE);
    assign reg_wr_en = (state == S_IDLE) && (state_nx == S_IO_WR);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Cycle context captured when a cycle begins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            page_q <= '0;
            rb_q   <= '0;
        end else if (start) begin
            ofs_q  <= win_ofs;
            page_q <= win_page;
            rb_q   <= rb_page;
        end
    end

    // Outputs from the current state.
    always_comb begin
        cs_active = 1'b0;
        sram_we_n = 1'b1;
        sram_oe_n = 1'b1;
        bus_doe   = 1'b0;
        bus_dout  = '0;
        unique case (state)
            S_IDLE, S_IO_WR: ;
            S_IO_RD: begin
                bus_doe  = 1'b1;
                bus_dout = rb_q;
            end
            S_MEM_WR: begin
                cs_active = 1'b1;
                sram_we_n = 1'b0;
            end
            S_MEM_RD: begin
                cs_active = 1'b1;
                sram_oe_n = 1'b0;
                bus_doe   = 1'b1;
                bus_dout  = sram_rdata;
            end
            default: ;
        endcase
    end

    assign sram_wdata = bus_din;
    assign sram_addr  = {page_q[PAGE_LO_W-1:0], ofs_q};

    for (genvar c = 0; c < N_CHIPS; c++) begin : g_cs
        assign sram_cs_n[c] = !(cs_active && (page_q[PAGE_W-1:PAGE_LO_W] == CHIP_SEL_W'(c)));
    end

    // R5: at most one device is ever selected.
    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sram_cs_n))
        else $error("several chip selects active");

    // R6: write and output enable never overlap.
    p_we_oe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n))
        else $error("we and oe both active");

    // R8: no device is selected while idle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (&sram_cs_n && sram_we_n && sram_oe_n))
        else $error("idle with SRAM active");

    // R10: a released read strobe returns the machine to idle.
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_MEM_RD) && memr_n) |=> (state == S_IDLE))
        else $error("read cycle did not end");

endmodule

// File: rtl/emm_mapper.sv
module emm_mapper #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 8,
    parameter int WIN_OFS_W   = 14,
    parameter int N_WIN       = 4,
    parameter int CHIP_ADDR_W = 19,
    parameter int IO_DEC_W    = 10,
    localparam int WIN_SEL_W  = $clog2(N_WIN),
    localparam int FRAME_W    = WIN_OFS_W + WIN_SEL_W,
    localparam int FB_W       = ADDR_W - FRAME_W,
    localparam int PB_W       = IO_DEC_W - WIN_SEL_W,
    localparam int PAGE_LO_W  = CHIP_ADDR_W - WIN_OFS_W,
    localparam int N_CHIPS    = 1 << (PAGE_W - PAGE_LO_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_din,
    output logic [DATA_W-1:0]      bus_dout,
    output logic                   bus_doe,
    input  logic                   iow_n,
    input  logic                   ior_n,
    input  logic                   memw_n,
    input  logic                   memr_n,
    input  logic [FB_W-1:0]        frame_base,
    input  logic [PB_W-1:0]        port_base,
    input  logic [DATA_W-1:0]      sram_rdata,
    output logic [DATA_W-1:0]      sram_wdata,
    output logic [CHIP_ADDR_W-1:0] sram_addr,
    output logic [N_CHIPS-1:0]     sram_cs_n,
    output logic                   sram_we_n,
    output logic                   sram_oe_n
);

    logic                 frame_en;
    logic                 mem_hit;
    logic                 io_hit;
    logic [WIN_SEL_W-1:0] win_sel;
    logic [WIN_SEL_W-1:0] reg_idx;
    logic [PAGE_W-1:0]    win_page;
    logic [PAGE_W-1:0]    rb_page;
    logic                 reg_wr_en;

    emm_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_OFS_W (WIN_OFS_W),
        .N_WIN     (N_WIN),
        .IO_DEC_W  (IO_DEC_W)
    ) u_decode (
        .mem_addr_hi (bus_addr[ADDR_W-1:WIN_OFS_W]),
        .io_addr     (bus_addr[IO_DEC_W-1:0]),
        .frame_base  (frame_base),
        .port_base   (port_base),
        .frame_en    (frame_en),
        .mem_hit     (mem_hit),
        .io_hit      (io_hit),
        .win_sel     (win_sel),
        .reg_idx     (reg_idx)
    );

    emm_page_regs #(
        .N_WIN  (N_WIN),
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_idx   (reg_idx),
        .wr_data  (bus_din[PAGE_W-1:0]),
        .win_idx  (win_sel),
        .rb_idx   (reg_idx),
        .win_page (win_page),
        .rb_page  (rb_page),
        .frame_en (frame_en)
    );

    emm_cycle_fsm #(
        .DATA_W      (DATA_W),
        .PAGE_W      (PAGE_W),
        .WIN_OFS_W   (WIN_OFS_W),
        .CHIP_ADDR_W (CHIP_ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .iow_n      (iow_n),
        .ior_n      (ior_n),
        .memw_n     (memw_n),
        .memr_n     (memr_n),
        .mem_hit    (mem_hit),
        .io_hit     (io_hit),
        .win_ofs    (bus_addr[WIN_OFS_W-1:0]),
        .win_page   (win_page),
        .rb_page    (rb_page),
        .bus_din    (bus_din),
        .sram_rdata (sram_rdata),
        .reg_wr_en  (reg_wr_en),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe),
        .sram_wdata (sram_wdata),
        .sram_addr  (sram_addr),
        .sram_cs_n  (sram_cs_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n)
    );

    // R1: a disarmed frame never selects a device.
    p_frame_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |-> (&sram_cs_n))
        else $error("device selected while frame disarmed");

    // R7: the host buffer is only driven after a read strobe was seen low.
    p_doe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> ($past(!ior_n) || $past(!memr_n)))
        else $error("buffer enabled without read strobe");

endmodule

// File: tb/emm_mapper_tb.sv
module emm_mapper_tb;

    localparam logic [3:0] FRAME = 4'hD;
    localparam logic [7:0] PORTB = 8'h9A;        // ports 0x268..0x26B
    localparam logic [7:0] FITTED = 8'b0011_1111; // devices 0..5 present
    localparam int NV = 19;

    // {op, address, data, expected}; op 0 IOW, 1 IOR, 2 MEMW, 3 MEMR
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 20'h00268, 8'h03, 8'h00},
        {2'd0, 20'h00269, 8'h04, 8'h00},
        {2'd0, 20'h0026A, 8'h05, 8'h00},
        {2'd0, 20'h0026B, 8'h06, 8'h00},
        {2'd1, 20'h0026A, 8'h00, 8'h05},
        {2'd2, 20'hD0010, 8'hA1, 8'h00},
        {2'd2, 20'hD4010, 8'hB2, 8'h00},
        {2'd2, 20'hDFFFF, 8'hC3, 8'h00},
        {2'd3, 20'hD0010, 8'h00, 8'hA1},
        {2'd3, 20'hD4010, 8'h00, 8'hB2},
        {2'd3, 20'hDFFFF, 8'h00, 8'hC3},
        {2'd0, 20'h00269, 8'hC0, 8'h00},
        {2'd3, 20'hD4010, 8'h00, 8'hFF},
        {2'd0, 20'h00269, 8'h25, 8'h00},
        {2'd2, 20'hD5234, 8'h5A, 8'h00},
        {2'd0, 20'h0026A, 8'h25, 8'h00},
        {2'd3, 20'hD9234, 8'h00, 8'h5A},
        {2'd1, 20'h0026B, 8'h00, 8'h06},
        {2'd1, 20'h00268, 8'h00, 8'h03}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic        iow_n = 1'b1, ior_n = 1'b1, memw_n = 1'b1, memr_n = 1'b1;
    logic [7:0]  bus_dout, sram_rdata, sram_wdata, sram_cs_n;
    logic        bus_doe, sram_we_n, sram_oe_n;
    logic [18:0] sram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mem [int];
    logic [7:0] shadow [4];

    logic [7:0]  s_dout, s_wd, s_cs;
    logic        s_doe, s_we, s_oe, s_doe2;
    logic [18:0] s_addr;

    always #5 clk = ~clk;

    emm_mapper u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_din    (bus_din),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe),
        .iow_n      (iow_n),
        .ior_n      (ior_n),
        .memw_n     (memw_n),
        .memr_n     (memr_n),
        .frame_base (FRAME),
        .port_base  (PORTB),
        .sram_rdata (sram_rdata),
        .sram_wdata (sram_wdata),
        .sram_addr  (sram_addr),
        .sram_cs_n  (sram_cs_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n)
    );

    function automatic int chip_of(input logic [7:0] cs);
        int r = -1;
        for (int c = 0; c < 8; c++) if (!cs[c]) r = c;
        return r;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] cs, input logic [18:0] a, input logic oe);
        int c = chip_of(cs);
        int key;
        if (oe || c < 0 || !FITTED[c]) return 8'hFF;
        key = (c << 19) | int'(a);
        if (mem.exists(key)) return mem[key];
        return 8'h00;
    endfunction

    assign sram_rdata = model_rd(sram_cs_n, sram_addr, sram_oe_n);

    always @(posedge clk) begin
        if (!sram_we_n && chip_of(sram_cs_n) >= 0 && FITTED[chip_of(sram_cs_n)])
            mem[(chip_of(sram_cs_n) << 19) | int'(sram_addr)] = sram_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, sample after one clock and again
    // after a second, release, then confirm idle one clock later (R10).
    task automatic bus_cycle(input logic [1:0] op, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_din  = d;
        case (op)
            2'd0: iow_n = 1'b0;
            2'd1: ior_n = 1'b0;
            2'd2: memw_n = 1'b0;
            default: memr_n = 1'b0;
        endcase
        @(negedge clk);
        s_dout = bus_dout; s_doe = bus_doe; s_cs = sram_cs_n;
        s_addr = sram_addr; s_we = sram_we_n; s_oe = sram_oe_n; s_wd = sram_wdata;
        @(negedge clk);
        s_doe2 = bus_doe;
        check(s_doe2 == s_doe, "R10 hold", 32'(s_doe2), 32'(s_doe));
        iow_n = 1'b1; ior_n = 1'b1; memw_n = 1'b1; memr_n = 1'b1;
        @(negedge clk);
        check(!bus_doe && (&sram_cs_n) && sram_we_n && sram_oe_n, "R10 release",
              {bus_doe, sram_cs_n}, {1'b0, 8'hFF});
    endtask

    task automatic check_mem_map(input logic [19:0] a, input string req);
        logic [7:0]  pg;
        logic [7:0]  ecs;
        logic [18:0] ea;
        pg  = shadow[a[15:14]];
        ecs = ~(8'b1 << pg[7:5]);
        ea  = {pg[4:0], a[13:0]};
        check(s_cs == ecs, {req, " chip select"}, 32'(s_cs), 32'(ecs));
        check(s_addr == ea, {req, " address"}, 32'(s_addr), 32'(ea));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) shadow[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check((&sram_cs_n) && !bus_doe && sram_we_n && sram_oe_n, "R1 reset outputs",
              {bus_doe, sram_cs_n}, {1'b0, 8'hFF});
        rst_n = 1'b1;
        @(negedge clk);

        // R1: registers read 00h, frame disarmed
        bus_cycle(2'd1, 20'h0026B, 8'h00);
        check(s_doe && s_dout == 8'h00, "R1 reset page", 32'(s_dout), 32'h0);
        bus_cycle(2'd3, 20'hD0000, 8'h00);
        check(!s_doe && (&s_cs), "R1 frame disarmed", {s_doe, s_cs}, {1'b0, 8'hFF});

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [19:0] a;
            logic [7:0]  d, e;
            {op, a, d, e} = VEC[i];
            bus_cycle(op, a, d);
            case (op)
                2'd0: begin
                    shadow[a[1:0]] = d;
                    check(!s_doe, "R2 write no drive", 32'(s_doe), 32'h0);
                end
                2'd1: check(s_doe && s_dout == e, "R2 readback", 32'(s_dout), 32'(e));
                2'd2: begin
                    check_mem_map(a, "R4 R5 write");
                    check(!s_we && s_oe && !s_doe && s_wd == d, "R6 write strobes",
                          {s_we, s_oe, s_doe, s_wd}, {3'b010, d});
                end
                default: begin
                    check_mem_map(a, "R4 R5 read");
                    check(!s_oe && s_we && s_doe && s_dout == e, "R7 read data",
                          {s_oe, s_we, s_doe, s_dout}, {3'b011, e});
                end
            endcase
            if (i >= 5 && i <= 10) begin
                // R9: consecutive pages 3..6 give a flat 64KB region
                logic [21:0] phys, want;
                phys = {3'(chip_of(s_cs)), s_addr};
                want = 22'(3 * 16384) + 22'(a[15:0]);
                check(phys == want, "R9 contiguous", 32'(phys), 32'(want));
            end
        end

        // R3: port just above the range must not touch register 0
        bus_cycle(2'd0, 20'h0026C, 8'h77);
        bus_cycle(2'd1, 20'h00264, 8'h00);
        check(!s_doe, "R3 io miss no drive", 32'(s_doe), 32'h0);
        bus_cycle(2'd1, 20'h00268, 8'h00);
        check(s_dout == 8'h03, "R3 register untouched", 32'(s_dout), 32'h03);

        // R8: outside the frame
        bus_cycle(2'd3, 20'hE0010, 8'h00);
        check(!s_doe && (&s_cs) && s_oe, "R8 read miss", {s_doe, s_cs}, {1'b0, 8'hFF});
        bus_cycle(2'd2, 20'hC0010, 8'h99);
        check(s_we && (&s_cs), "R8 write miss", {s_we, s_cs}, {1'b1, 8'hFF});

        // R5 R7: top page selects last device, which is absent
        bus_cycle(2'd0, 20'h00268, 8'hFF);
        shadow[0] = 8'hFF;
        bus_cycle(2'd3, 20'hD3FFF, 8'h00);
        check(s_cs == 8'h7F && s_addr == 19'h7FFFF, "R5 top page", {s_cs, s_addr}, {8'h7F, 19'h7FFFF});
        check(s_doe && s_dout == 8'hFF, "R7 absent reads FF", 32'(s_dout), 32'hFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule